// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block keeps two 32-bit event counters, named lower and upper, that share one control register. Each cycle, a counter adds one when the event pulse picked by its own select field is high and the processor's current privilege context is enabled. The enable bits for the user, supervisor and hypervisor contexts are common to both counters. A counter that should stay idle is therefore given a select code that matches no input, and it holds its value while the other counter keeps running.

When a counter rolls over from all ones to zero, a sticky overflow flag is set and the counter keeps counting. The interrupt output reports the flags, gated by the interrupt enable bit. Software reads both counters together as one 64-bit word. It can preload either half with the two's complement of N so that the half overflows after exactly N events. Privilege decoding stays outside the block, and a two-bit context input tells the block which context is current.

Top module: `dual_pmu`

## Requirements
- R1: After a synchronous reset, both counters, all control bits (enables, interrupt enable, both select fields) and both overflow flags read zero, and `irq` is low.
- R2: When its context is enabled, a counter adds exactly one in each cycle where `evt_in[sel]` is high, with `sel` taken from its select field. The lower select field is control bits [8:4] and the upper select field is bits [13:9].
- R3: Control bit 0 enables counting when `ctx_in`=0 (user), bit 1 when `ctx_in`=1 (supervisor) and bit 2 when `ctx_in`=2 (hypervisor). With `ctx_in`=3, or with the matching bit clear, neither counter changes.
- R4: A select code of 16 or above, including the park code 31, never counts, and the other counter is not affected.
- R5: A counter step from 0xFFFFFFFF to 0 sets that counter's overflow flag (`ovf[0]` for lower, `ovf[1]` for upper), and counting goes on from 0.
- R6: `irq` is high exactly when control bit 3 (interrupt enable) is set and at least one overflow flag is set.
- R7: A control write (`wr_addr`=0) clears both overflow flags if the stored interrupt enable was set before the write. Otherwise the flags are kept. A wrap in the same cycle still sets its flag.
- R8: A write with `wr_addr`=1 replaces the lower counter and a write with `wr_addr`=2 replaces the upper counter. The other half is unchanged. A write wins over an event in the same cycle, and `wr_addr`=3 changes nothing.
- R9: `cnt_word` carries the upper counter in bits 63:32 and the lower counter in bits 31:0. `ctrl_rd` returns the stored control value.
- R10: A counter preloaded with the two's complement of N sets its flag on the Nth counted event and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 lower counter, 2 upper counter, 3 unused |
| wr_data | input | 32 | Write data |
| ctx_in | input | 2 | Current privilege context: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| evt_in | input | NUM_EVT | Single-cycle event pulses |
| cnt_word | output | 64 | Upper and lower counters read as one word |
| ctrl_rd | output | 14 | Stored control register |
| ovf | output | 2 | Sticky overflow flags |
| irq | output | 1 | Overflow interrupt |

## Verification
On every cycle, the bound checker enforces the following rules:
- Counters freeze when no context is enabled or when a parked select code is programmed.
- A written counter half takes the written value.
- Flags never drop without a control write.
- A lower wrap always raises its flag.
- The interrupt stays low while it is masked.

Other behaviours depend on a chosen order of stimulus, and only the bench's scenarios show them:
- the exact count under mixed pulse patterns;
- the rule that the stored interrupt enable, not the newly written one, decides whether flags clear;
- overflow on exactly the Nth event after a preload;
- a write beating a coincident event.

// File: rtl/dpmu_pkg.sv
package dpmu_pkg;
    parameter int CNT_W   = 32;
    parameter int SEL_W   = 5;
    parameter int ADDR_W  = 2;
    parameter int N_LANES = 2;

    localparam int EN_BITS  = 4;
    localparam int CTRL_W   = EN_BITS + 2 * SEL_W;
    localparam int WORD_W   = N_LANES * CNT_W;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_LO   = 2'd1,
        ADDR_HI   = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        CTX_USER = 2'd0,
        CTX_SUP  = 2'd1,
        CTX_HV   = 2'd2,
        CTX_OFF  = 2'd3
    } ctx_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel_hi;
        logic [SEL_W-1:0] sel_lo;
        logic             irq_en;
        logic             hv_en;
        logic             sup_en;
        logic             usr_en;
    } ctrl_t;

    function automatic logic ctx_allowed(input ctrl_t c, input logic [1:0] ctx);
        logic ok;
        case (ctx_e'(ctx))
            CTX_USER: ok = c.usr_en;
            CTX_SUP:  ok = c.sup_en;
            CTX_HV:   ok = c.hv_en;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [SEL_W-1:0] lane_sel(input ctrl_t c, input int lane);
        return (lane == 0) ? c.sel_lo : c.sel_hi;
    endfunction
endpackage

// File: rtl/dpmu_evsel.sv
module dpmu_evsel
    import dpmu_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic [NUM_EVT-1:0] evt,
    input  logic [SEL_W-1:0]   sel,
    input  logic               allow,
    output logic               hit
);
    logic [NUM_EVT-1:0] match;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_match
        assign match[g] = evt[g] && (sel == SEL_W'(g));
    end

    assign hit = allow && (|match);
endmodule

// File: rtl/dpmu_counter.sv
module dpmu_counter
    import dpmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    logic             step;
    logic [CNT_W-1:0] cnt_d;

    assign step = inc && !load;
    assign wrap = step && (&cnt_q);

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (step)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dpmu_ctrl.sv
module dpmu_ctrl
    import dpmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ctrl,
    input  logic [CTRL_W-1:0]  wr_val,
    input  logic [N_LANES-1:0] ovf_set,
    output ctrl_t              ctrl_q,
    output logic [N_LANES-1:0] ovf_q
);
    logic [N_LANES-1:0] ovf_d;

    always_comb begin
        ovf_d = ovf_q;
        if (wr_ctrl && ctrl_q.irq_en)
            ovf_d = '0;
        ovf_d = ovf_d | ovf_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovf_q  <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wr_val);
            ovf_q <= ovf_d;
        end
    end
endmodule

// File: rtl/dual_pmu.sv
module dual_pmu
    import dpmu_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [1:0]          ctx_in,
    input  logic [NUM_EVT-1:0]  evt_in,
    output logic [WORD_W-1:0]   cnt_word,
    output logic [CTRL_W-1:0]   ctrl_rd,
    output logic [N_LANES-1:0]  ovf,
    output logic                irq
);
    ctrl_t              ctrl_q;
    logic [N_LANES-1:0] ovf_q;
    logic [N_LANES-1:0] lane_load;
    logic [N_LANES-1:0] lane_inc;
    logic [N_LANES-1:0] lane_wrap;
    logic [CNT_W-1:0]   lane_cnt [N_LANES];
    logic               allow;
    logic               wr_ctrl;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data[CNT_W-1:CTRL_W];
    assign allow   = ctx_allowed(ctrl_q, ctx_in);
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);

    dpmu_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_val  (wr_data[CTRL_W-1:0]),
        .ovf_set (lane_wrap),
        .ctrl_q  (ctrl_q),
        .ovf_q   (ovf_q)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam reg_addr_e LANE_ADDR = (g == 0) ? ADDR_LO : ADDR_HI;

        assign lane_load[g] = wr_en && (wr_addr == LANE_ADDR);

        dpmu_evsel #(.NUM_EVT(NUM_EVT)) u_sel (
            .evt   (evt_in),
            .sel   (lane_sel(ctrl_q, g)),
            .allow (allow),
            .hit   (lane_inc[g])
        );

        dpmu_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (lane_load[g]),
            .load_val (wr_data),
            .inc      (lane_inc[g]),
            .cnt_q    (lane_cnt[g]),
            .wrap     (lane_wrap[g])
        );

        assign cnt_word[g*CNT_W +: CNT_W] = lane_cnt[g];
    end

    assign ctrl_rd = ctrl_q;
    assign ovf     = ovf_q;
    assign irq     = ctrl_q.irq_en && (|ovf_q);
endmodule

// File: rtl/dpmu_chk.sv
module dpmu_chk
    import dpmu_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [CNT_W-1:0]    wr_data,
    input logic [1:0]          ctx_in,
    input logic [WORD_W-1:0]   cnt_word,
    input logic [CTRL_W-1:0]   ctrl_rd,
    input logic [N_LANES-1:0]  ovf,
    input logic                irq,
    input logic                inc_lo
);
    localparam int SEL_LO_POS = EN_BITS;
    localparam int IRQ_POS    = 3;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt_word == '0 && ovf == '0 && ctrl_rd == '0)); // R1

    AST_NO_CTX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && ctx_in == 2'd3) |=> $stable(cnt_word)); // R3

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[SEL_LO_POS +: SEL_W] >= SEL_W'(NUM_EVT) && !wr_en)
        |=> $stable(cnt_word[CNT_W-1:0])); // R4

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (inc_lo && !wr_en && cnt_word[CNT_W-1:0] == '1) |=> ovf[0]); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rd[IRQ_POS] |-> !irq); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_CTRL) |=> (($past(ovf) & ~ovf) == '0)); // R7

    AST_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_LO) |=> (cnt_word[CNT_W-1:0] == $past(wr_data))); // R8

    AST_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_LO && ctx_in == 2'd3)
        |=> $stable(cnt_word[WORD_W-1:CNT_W])); // R8
endmodule

bind dual_pmu dpmu_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctx_in   (ctx_in),
    .cnt_word (cnt_word),
    .ctrl_rd  (ctrl_rd),
    .ovf      (ovf),
    .irq      (irq),
    .inc_lo   (lane_inc[0])
);

// File: tb/dual_pmu_bench.sv
module dual_pmu_bench;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ctx_in = 2'd3;
    logic [NE-1:0] evt_in = '0;
    logic [63:0] cnt_word;
    logic [13:0] ctrl_rd;
    logic [1:0]  ovf;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R1";

    logic [31:0] m_lo, m_hi;
    logic [13:0] m_ctrl;
    logic [1:0]  m_flags;

    always #2.5 clk = ~clk;

    dual_pmu #(.NUM_EVT(NE)) u_dual_pmu (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctx_in(ctx_in), .evt_in(evt_in), .cnt_word(cnt_word), .ctrl_rd(ctrl_rd),
        .ovf(ovf), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_ctrl = 0; m_flags = 0;
        end else begin
            automatic bit en = (ctx_in != 3) && m_ctrl[ctx_in];
            automatic int slo = int'(m_ctrl[8:4]);
            automatic int shi = int'(m_ctrl[13:9]);
            automatic bit hlo = en && slo < NE && evt_in[slo];
            automatic bit hhi = en && shi < NE && evt_in[shi];
            automatic logic [1:0] nf = m_flags;
            if (wr_en && wr_addr == 0 && m_ctrl[3]) nf = 0;
            if (wr_en && wr_addr == 1) m_lo = wr_data;
            else if (hlo) begin
                if (m_lo == 32'hFFFF_FFFF) nf[0] = 1;
                m_lo = m_lo + 1;
            end
            if (wr_en && wr_addr == 2) m_hi = wr_data;
            else if (hhi) begin
                if (m_hi == 32'hFFFF_FFFF) nf[1] = 1;
                m_hi = m_hi + 1;
            end
            if (wr_en && wr_addr == 0) m_ctrl = wr_data[13:0];
            m_flags = nf;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "cnt_word", cnt_word, {m_hi, m_lo});
            chk(cur_req, "ovf", 64'(ovf), 64'(m_flags));
            chk(cur_req, "irq", 64'(irq), 64'(m_ctrl[3] && (m_flags != 0)));
            chk(cur_req, "ctrl_rd", 64'(ctrl_rd), 64'(m_ctrl));
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit u, input bit s, input bit h, input bit ie,
                                            input int lo, input int hi);
        return 32'({5'(hi), 5'(lo), ie, h, s, u});
    endfunction

    initial begin
        step(3);
        rst = 0;
        cur_req = "R1";
        chk("R1", "counters after reset", cnt_word, 64'd0);
        chk("R1", "flags after reset", 64'(ovf), 64'd0);
        chk("R1", "ctrl after reset", 64'(ctrl_rd), 64'd0);

        // R2: both counters on distinct sources, user context
        cur_req = "R2";
        ctx_in = 0;
        wr(0, mk_ctrl(1, 0, 0, 0, 2, 5));
        for (int i = 0; i < 40; i++) begin
            evt_in = NE'(i * 16'h2B5 ^ (i << 3));
            step();
        end
        evt_in = '0;

        // R3: context gating
        cur_req = "R3";
        begin
            automatic logic [63:0] snap = cnt_word;
            evt_in = '1; ctx_in = 3; step(4);
            chk("R3", "no context holds", cnt_word, snap);
            ctx_in = 1; step(4);
            chk("R3", "supervisor disabled holds", cnt_word, snap);
        end
        wr(0, mk_ctrl(0, 1, 0, 0, 2, 5));
        ctx_in = 1; step(3);
        ctx_in = 2; step(2);
        wr(0, mk_ctrl(0, 0, 1, 0, 2, 5));
        step(3);

        // R4: park the upper counter
        cur_req = "R4";
        wr(0, mk_ctrl(1, 1, 1, 0, 1, 31));
        begin
            automatic logic [31:0] hsnap = cnt_word[63:32];
            automatic logic [31:0] lsnap = cnt_word[31:0];
            ctx_in = 0; step(6);
            chk("R4", "parked upper holds", 64'(cnt_word[63:32]), 64'(hsnap));
            chk("R4", "lower keeps counting", 64'(cnt_word[31:0]), 64'(lsnap + 6));
        end
        wr(0, mk_ctrl(1, 1, 1, 0, 20, 1));
        step(3);

        // R8 / R9: half writes, write beats event
        cur_req = "R8";
        wr(1, 32'hDEAD_BEEF);
        chk("R9", "word layout lower", 64'(cnt_word[31:0]), 64'hDEAD_BEEF);
        wr(2, 32'h1234_5678);
        chk("R8", "upper written, lower kept", cnt_word, {32'h1234_5678, 32'hDEAD_BEEF});
        wr(3, 32'h5555_5555);
        evt_in = '0;
        wr(0, mk_ctrl(1, 0, 0, 0, 0, 0));
        evt_in = '1;
        wr(1, 32'h0000_0100);
        chk("R8", "write beats event (lower)", 64'(cnt_word[31:0]), 64'h100);
        evt_in = '0;

        // R10 / R5 / R6: preload -5 lower, -3 upper
        cur_req = "R10";
        wr(0, mk_ctrl(1, 0, 0, 0, 0, 3));
        wr(1, 32'hFFFF_FFFB);
        wr(2, 32'hFFFF_FFFD);
        evt_in = 16'h0001; step(4); evt_in = 0; step();
        chk("R10", "lower flag not before Nth", 64'(ovf[0]), 64'd0);
        evt_in = 16'h0001; step(); evt_in = 0;
        chk("R10", "lower flag on Nth", 64'(ovf[0]), 64'd1);
        chk("R5", "lower wrapped to zero", 64'(cnt_word[31:0]), 64'd0);
        cur_req = "R5";
        evt_in = 16'h0001; step(2); evt_in = 0;
        chk("R5", "lower keeps running", 64'(cnt_word[31:0]), 64'd2);
        chk("R6", "irq masked", 64'(irq), 64'd0);
        evt_in = 16'h0008; step(3); evt_in = 0;
        chk("R10", "upper flag on 3rd", 64'(ovf), 64'd3);
        cur_req = "R7";
        wr(0, mk_ctrl(1, 0, 0, 1, 0, 3));
        chk("R7", "flags kept when stored irq_en clear", 64'(ovf), 64'd3);
        chk("R6", "irq raised", 64'(irq), 64'd1);
        wr(0, mk_ctrl(1, 0, 0, 1, 0, 3));
        chk("R7", "flags cleared", 64'(ovf), 64'd0);
        chk("R6", "irq dropped", 64'(irq), 64'd0);
        // wrap in same cycle as clearing write
        wr(1, 32'hFFFF_FFFF);
        evt_in = 16'h0001;
        wr(0, mk_ctrl(1, 0, 0, 1, 0, 3));
        evt_in = 0;
        chk("R7", "same-cycle wrap keeps flag", 64'(ovf), 64'd1);

        // reset again mid-run
        cur_req = "R1";
        rst = 1; step(); rst = 0;
        chk("R1", "reset clears all", {cnt_word[63:2], ovf}, 64'd0);
        step(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule